// File: doc/BRIEF.md
# Programmable Eight-Line Interrupt Controller

This block takes eight interrupt request lines and resolves them by priority. It raises one interrupt line toward a processor and, on an acknowledge strobe, returns an 8-bit vector. The vector is a programmable base with the winning line number in its three low bits. Software programs the block through a two-address byte port. After reset it waits for an initialization sequence. It then accepts operation words for masking, end-of-interrupt, priority rotation, polling and status readback.

The block keeps three byte-wide registers: a request register, an in-service register and a mask. Requests are taken on rising edges or on levels. End-of-interrupt is issued either by software command or automatically as part of the acknowledge. Priority starts fixed with line 0 highest, and rotation commands can move it. Only a single controller is supported.

Top module: `irq_ctrl8`

## Requirements
- R1: From reset, and from any write at address 0 with data bit 4 set, `int_out` stays low until the initialization sequence has finished. That write also clears the mask, the in-service bits, the request bits, special mask mode and any pending poll, and it restores line 0 as highest priority.
- R2: After the start word, the next address-1 write sets the vector base from data bits 7:3. If bit 1 of the start word is 0, one further address-1 write is taken and ignored. If bit 0 of the start word is 1, one more address-1 write is taken as the mode word. Only then does operation begin. From then on, address-1 writes load the mask.
- R3: An `inta` pulse registers `vector` = {base, line} in the following cycle and marks that line in service. If nothing is eligible, `vector` = {base, 3'b111} and no register changes.
- R4: Mask bit n blocks line n from `int_out` and from acknowledge. A read at address 1 returns the mask.
- R5: Priority starts fixed with line 0 highest. A request is eligible only if it is ranked above every in-service line.
- R6: An address-0 write with bits 4 and 3 clear and bit 5 set is an end-of-interrupt. With bit 6 clear it clears the highest-ranked in-service bit. With bit 6 set it clears the bit named by data bits 2:0.
- R7: If bit 7 is also set on an end-of-interrupt, the cleared line becomes lowest priority and the other lines follow in circular order. Bits 7 and 6 set with bit 5 clear make line data[2:0] lowest priority directly.
- R8: When bit 1 of the mode word is 1, acknowledge does not set any in-service bit.
- R9: When bit 3 of the start word is 0, a rising edge latches a request bit that holds until acknowledged. When it is 1, the request register follows the inputs, one cycle late.
- R10: An address-0 write with bit 3 set and bit 4 clear is a read/poll word. If bit 1 is set, bit 0 selects what address-0 reads return: the in-service register (1) or the request register (0).
- R11: If bit 2 of a read/poll word is set, the next address-0 read returns {pending, 4'b0, line}, with line equal to 0 when nothing is pending. That read acknowledges the line in the same way as `inta`.
- R12: In a read/poll word, bit 6 set loads special mask mode from bit 5. While special mask mode is on, in-service lines no longer block other lines. Only masked lines and the in-service lines themselves are excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register port address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Read data, valid during `rd` |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe, one cycle |
| int_out | output | 1 | Interrupt to the processor |
| vector | output | 8 | Vector of the last acknowledge |

## Verification
The block has no parameters, because the byte-wide register port fixes the line count at eight. The bench therefore builds the only configuration there is. Directed sequences cover nesting, both end-of-interrupt forms, rotation from two starting points, polling, special mask mode, level triggering with automatic end-of-interrupt, and the shortened and full initialization sequences. A random phase then reinitializes the block with random bases, masks and request bursts. In each round it compares the interrupt line and the acknowledged vector against a lowest-set-bit model.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  input  logic       inta,
  output logic       int_out,
  output logic [7:0] vector
);

  typedef enum logic [1:0] {S_RUN, S_W2, S_W3, S_W4} seq_t;

  seq_t       seq;
  logic       cfg_done, level_mode, single, need4, aeoi, smm, read_isr, poll_armed;
  logic [4:0] base;
  logic [2:0] low_lvl;
  logic [7:0] irr, isr, imr, prev;

  function automatic logic [2:0] rank(input logic [2:0] n, input logic [2:0] low);
    return n - low - 3'd1;
  endfunction

  wire run      = (seq == S_RUN) && cfg_done;
  wire wr0      = wr && !addr;
  wire wr1      = wr && addr;
  wire start_w  = wr0 && wdata[4];
  wire cmd_w    = wr0 && !wdata[4] && !wdata[3] && run;
  wire ctl_w    = wr0 && !wdata[4] && wdata[3] && run;
  wire poll_rd  = rd && !addr && poll_armed && run;

  logic [7:0] req, elig;
  logic       req_hit, isr_hit, win_valid;
  logic [2:0] req_lvl, isr_lvl;

  always_comb begin
    req     = irr & ~imr;
    elig    = smm ? (req & ~isr) : req;
    req_hit = 1'b0;
    req_lvl = 3'd0;
    isr_hit = 1'b0;
    isr_lvl = 3'd0;
    for (int k = 7; k >= 0; k--) begin
      logic [2:0] idx;
      idx = low_lvl + 3'd1 + 3'(k);
      if (elig[idx]) begin
        req_hit = 1'b1;
        req_lvl = idx;
      end
      if (isr[idx]) begin
        isr_hit = 1'b1;
        isr_lvl = idx;
      end
    end
  end

  assign win_valid = req_hit && (smm || !isr_hit || rank(req_lvl, low_lvl) < rank(isr_lvl, low_lvl));
  assign int_out   = cfg_done && win_valid;

  wire        do_ack   = (inta || poll_rd) && cfg_done;
  wire [7:0]  ack_mask = (do_ack && win_valid) ? (8'h01 << req_lvl) : 8'h00;

  wire        eoi      = cmd_w && wdata[5];
  wire [2:0]  eoi_lvl  = wdata[6] ? wdata[2:0] : isr_lvl;
  wire        eoi_do   = eoi && (wdata[6] || isr_hit);
  wire [7:0]  eoi_mask = eoi_do ? (8'h01 << eoi_lvl) : 8'h00;

  always_comb begin
    if (addr)
      rdata = imr;
    else if (poll_armed)
      rdata = {win_valid, 4'b0000, win_valid ? req_lvl : 3'd0};
    else
      rdata = read_isr ? isr : irr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq        <= S_RUN;
      cfg_done   <= 1'b0;
      level_mode <= 1'b0;
      single     <= 1'b1;
      need4      <= 1'b0;
      aeoi       <= 1'b0;
      smm        <= 1'b0;
      read_isr   <= 1'b0;
      poll_armed <= 1'b0;
      base       <= 5'd0;
      low_lvl    <= 3'd7;
      irr        <= 8'h00;
      isr        <= 8'h00;
      imr        <= 8'h00;
      prev       <= 8'h00;
      vector     <= 8'h00;
    end else begin
      prev <= irq_in;

      if (start_w)
        irr <= 8'h00;
      else if (level_mode)
        irr <= irq_in;
      else
        irr <= (irr & ~ack_mask) | (irq_in & ~prev);

      if (do_ack)
        vector <= {base, win_valid ? req_lvl : 3'd7};

      if (start_w) begin
        seq        <= S_W2;
        cfg_done   <= 1'b0;
        level_mode <= wdata[3];
        single     <= wdata[1];
        need4      <= wdata[0];
        aeoi       <= 1'b0;
        smm        <= 1'b0;
        read_isr   <= 1'b0;
        poll_armed <= 1'b0;
        low_lvl    <= 3'd7;
        isr        <= 8'h00;
        imr        <= 8'h00;
      end else begin
        isr <= (isr & ~eoi_mask) | (aeoi ? 8'h00 : ack_mask);

        if (eoi_do && wdata[7])
          low_lvl <= eoi_lvl;
        else if (cmd_w && !wdata[5] && wdata[7] && wdata[6])
          low_lvl <= wdata[2:0];

        if (poll_rd)
          poll_armed <= 1'b0;
        if (ctl_w) begin
          poll_armed <= wdata[2];
          if (wdata[1]) read_isr <= wdata[0];
          if (wdata[6]) smm <= wdata[5];
        end

        if (wr1) begin
          case (seq)
            S_W2: begin
              base <= wdata[7:3];
              if (!single) seq <= S_W3;
              else if (need4) seq <= S_W4;
              else begin
                seq      <= S_RUN;
                cfg_done <= 1'b1;
              end
            end
            S_W3: begin
              if (need4) seq <= S_W4;
              else begin
                seq      <= S_RUN;
                cfg_done <= 1'b1;
              end
            end
            S_W4: begin
              aeoi     <= wdata[1];
              seq      <= S_RUN;
              cfg_done <= 1'b1;
            end
            default: if (cfg_done) imr <= wdata;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inta,
  input logic       wr,
  input logic       int_out,
  input logic       cfg_done,
  input logic       aeoi,
  input logic       level_mode,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic [7:0] irq_in,
  input logic [7:0] vector
);

  a_r1_quiet_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !int_out);

  a_r4_masked_never_raise: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != 8'h00));

  a_r3_ack_marks_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (!aeoi && inta && int_out && !wr) |=> isr[vector[2:0]]);

  a_r8_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && inta && !wr) |=> (isr == $past(isr)));

  a_r9_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && $past(level_mode) && !$past(wr)) |-> (irr == $past(irq_in)));

endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .wr(wr), .int_out(int_out),
  .cfg_done(cfg_done), .aeoi(aeoi), .level_mode(level_mode),
  .irr(irr), .isr(isr), .imr(imr), .irq_in(irq_in), .vector(vector)
);

// File: tb/irq_ctrl8_test.sv
module irq_ctrl8_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, inta = 1'b0;
  logic [7:0] wdata = 8'h00, irq = 8'h00;
  logic [7:0] rdata, vector;
  logic       int_out;
  int         tests = 0, fails = 0;
  logic       finished = 1'b0;

  irq_ctrl8 uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .irq_in(irq), .inta(inta), .int_out(int_out), .vector(vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0; v = vector;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic init(input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w4);
    wreg(1'b0, w1 | 8'h10);
    wreg(1'b1, w2);
    if (!w1[1]) wreg(1'b1, 8'h00);
    if (w1[0]) wreg(1'b1, w4);
  endtask

  task automatic chk_int(input string rq, input logic exp);
    check(rq, {7'b0, int_out}, {7'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v, base, m, p, exp;
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, no interrupt before configuration
    chk_int("R1 reset int", 1'b0);
    rreg(1'b1, d); check("R1 reset mask", d, 8'h00);
    lines(8'h01); chk_int("R1 unconfigured", 1'b0);

    // R9: edge mode, line already high gives no request
    init(8'h03, 8'h40, 8'h00);
    chk_int("R9 no edge", 1'b0);
    lines(8'h00);

    // R4: mask
    wreg(1'b1, 8'h05); rreg(1'b1, d); check("R4 mask read", d, 8'h05);
    lines(8'h01); chk_int("R4 masked", 1'b0);
    wreg(1'b1, 8'h00); chk_int("R4 unmasked", 1'b1);
    lines(8'h00); chk_int("R9 edge held", 1'b1);

    // R3, R10
    ack(v); check("R3 vector", v, 8'h40);
    wreg(1'b0, 8'h0B); rreg(1'b0, d); check("R10 isr read", d, 8'h01);
    wreg(1'b0, 8'h0A); rreg(1'b0, d); check("R10 irr read", d, 8'h00);

    // R5, R6: nesting and end-of-interrupt
    lines(8'h08); chk_int("R5 lower blocked", 1'b0);
    wreg(1'b0, 8'h20); chk_int("R6 eoi frees", 1'b1);
    ack(v); check("R3 vector 3", v, 8'h43);
    lines(8'h00);
    lines(8'h02); chk_int("R5 higher nests", 1'b1);
    ack(v); check("R5 nested vector", v, 8'h41);
    wreg(1'b0, 8'h20);
    wreg(1'b0, 8'h0B); rreg(1'b0, d); check("R6 nonspecific", d, 8'h08);
    wreg(1'b0, 8'h63); rreg(1'b0, d); check("R6 specific", d, 8'h00);
    lines(8'h00);

    // R3: spurious acknowledge
    ack(v); check("R3 spurious", v, 8'h47);
    rreg(1'b0, d); check("R3 spurious isr", d, 8'h00);

    // R7: rotation
    lines(8'h04); ack(v); check("R7 pre", v, 8'h42);
    wreg(1'b0, 8'hA0);
    lines(8'h00); lines(8'h12);
    ack(v); check("R7 rotated winner", v, 8'h44);
    wreg(1'b0, 8'h20);
    ack(v); check("R7 rotated second", v, 8'h41);
    wreg(1'b0, 8'h20);
    lines(8'h00);
    wreg(1'b0, 8'hC0);
    lines(8'h21);
    ack(v); check("R7 set priority", v, 8'h45);
    wreg(1'b0, 8'h20);
    ack(v); check("R7 set priority next", v, 8'h40);
    wreg(1'b0, 8'h20);
    lines(8'h00);
    wreg(1'b0, 8'hC7);

    // R11: poll
    lines(8'h40);
    wreg(1'b0, 8'h0C); rreg(1'b0, d); check("R11 poll", d, 8'h86);
    rreg(1'b0, d); check("R11 poll acks", d, 8'h40);
    wreg(1'b0, 8'h20); lines(8'h00);
    wreg(1'b0, 8'h0C); rreg(1'b0, d); check("R11 poll empty", d, 8'h00);

    // R12: special mask mode
    lines(8'h04); ack(v); check("R12 pre", v, 8'h42);
    lines(8'h24); chk_int("R12 blocked", 1'b0);
    wreg(1'b0, 8'h68); chk_int("R12 smm on", 1'b1);
    wreg(1'b0, 8'h48); chk_int("R12 smm off", 1'b0);
    wreg(1'b0, 8'h62); chk_int("R12 after eoi", 1'b1);
    ack(v); check("R12 vector", v, 8'h45);
    wreg(1'b0, 8'h20); lines(8'h00);

    // R8, R9: level mode with automatic end-of-interrupt
    init(8'h0B, 8'h80, 8'h02);
    lines(8'h08); chk_int("R9 level", 1'b1);
    lines(8'h00); chk_int("R9 level drop", 1'b0);
    lines(8'h08); ack(v); check("R8 vector", v, 8'h83);
    wreg(1'b0, 8'h0B); rreg(1'b0, d); check("R8 isr empty", d, 8'h00);
    chk_int("R8 level reasserts", 1'b1);
    lines(8'h00);

    // R2: cascaded sequence takes a third word
    wreg(1'b0, 8'h10); wreg(1'b1, 8'h20);
    lines(8'h10); chk_int("R2 waits word 3", 1'b0);
    wreg(1'b1, 8'h00); chk_int("R2 done", 1'b1);
    wreg(1'b1, 8'h10); chk_int("R2 mask after", 1'b0);
    rreg(1'b1, d); check("R2 mask read", d, 8'h10);
    lines(8'h00);

    // R3, R4, R5: random rounds
    for (int it = 0; it < 40; it++) begin
      base = 8'($urandom) & 8'hF8;
      m    = 8'($urandom);
      p    = 8'($urandom);
      init(8'h03, base, 8'h02);
      wreg(1'b1, m);
      lines(p); lines(8'h00);
      exp = p & ~m;
      chk_int("R4 random int", |exp);
      if (|exp) begin
        ack(v); check("R5 random vector", v, base | {5'b0, lowest(exp)});
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule